// File: doc/BRIEF.md
# Page-Directory-Pointer Register Loader

This block keeps the four 64-bit directory-pointer registers that a 32-bit paging unit with physical address extension consults at the top of every walk. It watches control-register write events. When one of them calls for a reload, it forms a 32-byte-aligned table base from the CR3 value in effect and reads the four table entries, as eight 32-bit words, over a simple request/acknowledge read port.

Once the last word arrives, the block checks each entry for reserved bits. If all four are acceptable, it replaces every register in the same cycle. If any entry fails, it raises a one-cycle general-protection fault with error code zero and leaves the old register contents untouched. A read-only selector returns the register that covers a given linear address. A reload request that arrives while a load is running is kept in a single slot, and only the most recent request is kept.

Top module: `pdpt_loader`

## Requirements
- R1: After reset, all four registers read as zero, `busy` is low and `rd_req` is low.
- R2: The table base is CR3 with bits 4:0 cleared. Those five bits have no effect. Word k (k = 0..7) is read from base + 4k in ascending order, and word k fills entry k/2: the low half when k is even, the high half when k is odd.
- R3: `dp_entry` shows the register numbered by `lin_addr[31:30]`.
- R4: A write of kind 2'b01 (CR3) starts a reload from the written value only when the current CR0 bit 31 and the current CR4 bit 5 are both set.
- R5: A write of kind 2'b00 (CR0) starts a reload from the current CR3 when the new bit 31 and the current CR4 bit 5 are both set and at least one of CR0 bits 31, 30 or 29 changes.
- R6: A write of kind 2'b10 (CR4) starts a reload from the current CR3 when the current CR0 bit 31 and the new bit 5 are both set and at least one of CR4 bits 4, 5, 7 or 20 changes.
- R7: A write of kind 2'b11 (task switch loading CR3) starts a reload from the new value only when CR0 bit 31 and CR4 bit 5 are set and the new value differs from the current CR3.
- R8: An entry is invalid when bit 0 is set together with any of bits 2:1, 8:5 or 63 down to `PA_W` (the parameter lies between 32 and 52). Reserved bits are not checked in an entry whose bit 0 is clear.
- R9: If any entry is invalid, `gp_fault` pulses for one cycle with `gp_errcode` equal to 0 and no register changes. Otherwise `commit` pulses for one cycle and all four registers take the new entries together.
- R10: `busy` is high from the start of the fetch through the cycle of the commit or fault pulse. A pending `rd_req` stays high with a stable address until `rd_ack` is seen.
- R11: A reload request made while `busy` is high is held and served after the current load ends. A later request replaces an earlier held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle control-register write event |
| wr_kind | input | 2 | 00 CR0, 01 CR3, 10 CR4, 11 task switch |
| wr_data | input | 32 | Value being written |
| cur_cr0 | input | 32 | CR0 before the write |
| cur_cr3 | input | 32 | CR3 before the write |
| cur_cr4 | input | 32 | CR4 before the write |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read word address (byte address) |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| lin_addr | input | 32 | Linear address for register select |
| dp_entry | output | 64 | Selected directory-pointer register |
| busy | output | 1 | Load in progress |
| commit | output | 1 | Pulse: all registers updated |
| gp_fault | output | 1 | Pulse: invalid entry, registers kept |
| gp_errcode | output | 16 | Fault error code |

## Verification
The assertions assume that `rd_ack` is only asserted while `rd_req` is high and that `rd_data` is valid in the same cycle. They also assume that the `cur_cr*` inputs hold the register values in effect before each write event. The bench drives every input on the falling edge. Its memory model acknowledges a request one half-cycle after it appears. After each write event, the bench updates its own copy of the control registers, so that the `cur_cr*` inputs always describe the state before the next write.

// File: rtl/pdpt_pkg.sv
package pdpt_pkg;

  localparam int NENT   = 4;
  localparam int NWORDS = 2 * NENT;
  localparam int WIDX_W = $clog2(NWORDS);

  typedef enum logic [1:0] {
    WK_CR0  = 2'b00,
    WK_CR3  = 2'b01,
    WK_CR4  = 2'b10,
    WK_TASK = 2'b11
  } wr_kind_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'b00,
    F_READ = 2'b01,
    F_FIN  = 2'b10
  } fetch_st_e;

  typedef logic [NENT-1:0][63:0] ent_set_t;

  localparam int CR0_PG   = 31;
  localparam int CR0_CD   = 30;
  localparam int CR0_NW   = 29;
  localparam int CR4_PSE  = 4;
  localparam int CR4_PAE  = 5;
  localparam int CR4_PGE  = 7;
  localparam int CR4_SMEP = 20;

  function automatic logic [31:0] cr0_watch();
    logic [31:0] m;
    m = '0;
    m[CR0_PG] = 1'b1;
    m[CR0_CD] = 1'b1;
    m[CR0_NW] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] cr4_watch();
    logic [31:0] m;
    m = '0;
    m[CR4_PSE]  = 1'b1;
    m[CR4_PAE]  = 1'b1;
    m[CR4_PGE]  = 1'b1;
    m[CR4_SMEP] = 1'b1;
    return m;
  endfunction

  // 32-byte aligned table base
  function automatic logic [31:0] tbl_base(input logic [31:0] cr3);
    return {cr3[31:5], 5'b00000};
  endfunction

  // address of word k of the table
  function automatic logic [31:0] word_addr(input logic [31:0] base,
                                             input logic [WIDX_W-1:0] k);
    return base + {{(30-WIDX_W){1'b0}}, k, 2'b00};
  endfunction

  // reserved-bit mask for a given physical-address width
  function automatic logic [63:0] rsvd_mask(input int pa_w);
    logic [63:0] m;
    m = 64'h0000_0000_0000_01E6;
    for (int b = 0; b < 64; b++) begin
      if (b >= pa_w) m[b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic ent_bad(input logic [63:0] e, input int pa_w);
    return e[0] && ((e & rsvd_mask(pa_w)) != 64'd0);
  endfunction

endpackage

// File: rtl/pdpt_trigger.sv
module pdpt_trigger
  import pdpt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [1:0]  wr_kind,
  input  logic [31:0] wr_data,
  input  logic [31:0] cur_cr0,
  input  logic [31:0] cur_cr3,
  input  logic [31:0] cur_cr4,
  input  logic        take,
  output logic        fire,
  output logic        pend_vld,
  output logic [31:0] pend_base
);

  logic        pae_now;
  logic        hit;
  logic [31:0] src_cr3;

  assign pae_now = cur_cr0[CR0_PG] && cur_cr4[CR4_PAE];

  always_comb begin
    hit     = 1'b0;
    src_cr3 = cur_cr3;
    unique case (wr_kind_e'(wr_kind))
      WK_CR0: hit = wr_data[CR0_PG] && cur_cr4[CR4_PAE] &&
                    (((wr_data ^ cur_cr0) & cr0_watch()) != 32'd0);
      WK_CR4: hit = cur_cr0[CR0_PG] && wr_data[CR4_PAE] &&
                    (((wr_data ^ cur_cr4) & cr4_watch()) != 32'd0);
      WK_CR3: begin
        hit     = pae_now;
        src_cr3 = wr_data;
      end
      WK_TASK: begin
        hit     = pae_now && (wr_data != cur_cr3);
        src_cr3 = wr_data;
      end
      default: hit = 1'b0;
    endcase
  end

  assign fire = wr_valid && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_base <= '0;
    end else if (fire) begin
      pend_vld  <= 1'b1;
      pend_base <= tbl_base(src_cr3);
    end else if (take) begin
      pend_vld  <= 1'b0;
    end
  end

  // R11: a request is never lost
  p_fire_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pend_vld);
  // R11: a waiting request keeps its base until taken or replaced
  p_pend_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && !take && !fire) |=> (pend_vld && $stable(pend_base)));

endmodule

// File: rtl/pdpt_fetch.sv
module pdpt_fetch
  import pdpt_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_base,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_ack,
  input  logic [31:0] rd_data,
  output logic        busy,
  output logic        commit,
  output logic        fault,
  output ent_set_t    ent_set
);

  fetch_st_e          st;
  logic [31:0]        base_q;
  logic [WIDX_W-1:0]  widx;
  ent_set_t           ebuf;
  logic [NENT-1:0]    bad;
  logic               any_bad;
  logic               word_take;

  assign word_take = (st == F_READ) && rd_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      base_q <= '0;
      widx   <= '0;
      ebuf   <= '0;
    end else begin
      unique case (st)
        F_IDLE: if (start) begin
          st     <= F_READ;
          base_q <= start_base;
          widx   <= '0;
        end
        F_READ: if (word_take) begin
          if (widx[0]) ebuf[widx[WIDX_W-1:1]][63:32] <= rd_data;
          else         ebuf[widx[WIDX_W-1:1]][31:0]  <= rd_data;
          if (widx == WIDX_W'(NWORDS - 1)) st <= F_FIN;
          else                               widx <= widx + 1'b1;
        end
        F_FIN: st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NENT; g++) begin : g_chk
    assign bad[g] = ent_bad(ebuf[g], PA_W);
  end

  assign any_bad = |bad;
  assign rd_req  = (st == F_READ);
  assign rd_addr = word_addr(base_q, widx);
  assign busy    = (st != F_IDLE);
  assign commit  = (st == F_FIN) && !any_bad;
  assign fault   = (st == F_FIN) && any_bad;
  assign ent_set = ebuf;

  // R10: request held with a stable address until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
  // R2: every fetch begins at a 32-byte aligned address
  p_first_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> (rd_addr[4:0] == 5'd0));
  // R9: commit and fault are exclusive
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && fault));
  // R10: busy drops right after the outcome pulse
  p_busy_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || fault) |=> !busy);

endmodule

// File: rtl/pdpt_regs.sv
module pdpt_regs
  import pdpt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        commit,
  input  ent_set_t    ent_set,
  input  logic [31:0] lin_addr,
  output logic [63:0] dp_entry
);

  ent_set_t regs;

  always_ff @(posedge clk) begin
    if (!rst_n)      regs <= '0;
    else if (commit) regs <= ent_set;
  end

  assign dp_entry = regs[lin_addr[31:30]];

  // R9: contents change only through a commit
  p_hold_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(regs));

endmodule

// File: rtl/pdpt_loader.sv
module pdpt_loader
  import pdpt_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [1:0]  wr_kind,
  input  logic [31:0] wr_data,
  input  logic [31:0] cur_cr0,
  input  logic [31:0] cur_cr3,
  input  logic [31:0] cur_cr4,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_ack,
  input  logic [31:0] rd_data,
  input  logic [31:0] lin_addr,
  output logic [63:0] dp_entry,
  output logic        busy,
  output logic        commit,
  output logic        gp_fault,
  output logic [15:0] gp_errcode
);

  logic        fire;
  logic        pend_vld;
  logic [31:0] pend_base;
  logic        take;
  ent_set_t    ent_set;

  assign take = pend_vld && !busy;

  pdpt_trigger u_trig (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_kind(wr_kind), .wr_data(wr_data),
    .cur_cr0(cur_cr0), .cur_cr3(cur_cr3), .cur_cr4(cur_cr4),
    .take(take), .fire(fire), .pend_vld(pend_vld), .pend_base(pend_base)
  );

  pdpt_fetch #(.PA_W(PA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .start(take), .start_base(pend_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .commit(commit), .fault(gp_fault), .ent_set(ent_set)
  );

  pdpt_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .ent_set(ent_set),
    .lin_addr(lin_addr), .dp_entry(dp_entry)
  );

  assign gp_errcode = 16'h0000;

  // R11: a waiting request starts a fetch once the engine is idle
  p_take_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy);

endmodule

// File: tb/sim_pdpt_loader.sv
module sim_pdpt_loader;

  localparam int PA_W = 36;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_kind = 2'b00;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_cr0 = '0, cur_cr3 = '0, cur_cr4 = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic [31:0] lin_addr = '0;
  logic [63:0] dp_entry;
  logic        busy, commit, gp_fault;
  logic [15:0] gp_errcode;

  int checks = 0;
  int fails  = 0;
  int n_commit = 0, n_fault = 0, n_badcode = 0;
  bit busy_seen = 1'b0;
  logic [31:0] mem [0:255];
  logic [31:0] alog [0:31];
  int acnt = 0;
  logic [63:0] exp_e [0:3];

  always #2.5 clk = ~clk;

  pdpt_loader #(.PA_W(PA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_kind(wr_kind),
    .wr_data(wr_data), .cur_cr0(cur_cr0), .cur_cr3(cur_cr3), .cur_cr4(cur_cr4),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .lin_addr(lin_addr), .dp_entry(dp_entry), .busy(busy), .commit(commit),
    .gp_fault(gp_fault), .gp_errcode(gp_errcode)
  );

  // memory model and event monitor, all on the falling edge
  always @(negedge clk) begin
    if (rd_req) begin
      rd_ack  <= 1'b1;
      rd_data <= mem[rd_addr[9:2]];
      if (acnt < 32) alog[acnt] <= rd_addr;
      acnt <= acnt + 1;
    end else begin
      rd_ack <= 1'b0;
    end
    if (busy) busy_seen <= 1'b1;
    if (commit) n_commit <= n_commit + 1;
    if (gp_fault) begin
      n_fault <= n_fault + 1;
      if (gp_errcode != 16'h0000) n_badcode <= n_badcode + 1;
    end
  end

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // bench's own validity rule, bit by bit
  function automatic bit bench_bad(input logic [63:0] e);
    bit r = 1'b0;
    for (int b = 0; b < 64; b++) begin
      if (e[b] && (b == 1 || b == 2 || (b >= 5 && b <= 8) || b >= PA_W)) r = 1'b1;
    end
    return e[0] && r;
  endfunction

  task automatic put_tbl(input logic [31:0] base, input logic [63:0] e0, e1, e2, e3);
    logic [63:0] t [0:3];
    t[0] = e0; t[1] = e1; t[2] = e2; t[3] = e3;
    for (int k = 0; k < 4; k++) begin
      mem[(base >> 2) + 2*k]     = t[k][31:0];
      mem[(base >> 2) + 2*k + 1] = t[k][63:32];
    end
  endtask

  function automatic logic [63:0] tbl_ent(input logic [31:0] base, input int k);
    return {mem[(base >> 2) + 2*k + 1], mem[(base >> 2) + 2*k]};
  endfunction

  task automatic set_exp_from(input logic [31:0] base);
    for (int k = 0; k < 4; k++) exp_e[k] = tbl_ent(base, k);
  endtask

  task automatic do_write(input logic [1:0] kind, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_kind = kind; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    case (kind)
      2'b00: cur_cr0 = d;
      2'b10: cur_cr4 = d;
      default: cur_cr3 = d;
    endcase
  endtask

  task automatic arm();
    @(negedge clk);
    busy_seen = 1'b0;
    acnt = 0;
  endtask

  task automatic settle();
    int n = 0;
    repeat (3) @(negedge clk);
    while (busy && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_regs(input string rq);
    for (int i = 0; i < 4; i++) begin
      lin_addr = {i[1:0], 30'h0ABC_DEF0};
      #1;
      check(rq, dp_entry, exp_e[i]);
    end
  endtask

  task automatic expect_load(input string rq, input int c0, input bit fault_exp);
    check({rq, " outcome commit"}, 64'(n_commit - c0), fault_exp ? 64'd0 : 64'd1);
    check({rq, " busy seen"}, 64'(busy_seen), 64'd1);
  endtask

  task automatic expect_none(input string rq, input int c0, input int f0);
    check({rq, " no load busy"}, 64'(busy_seen), 64'd0);
    check({rq, " no commit"}, 64'(n_commit - c0), 64'd0);
    check({rq, " no fault"}, 64'(n_fault - f0), 64'd0);
  endtask

  // R1
  task automatic t_reset();
    for (int k = 0; k < 4; k++) exp_e[k] = 64'd0;
    check_regs("R1 reset regs");
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 rd_req", 64'(rd_req), 64'd0);
  endtask

  // R4 and R6: no reload while paging is off
  task automatic t_inactive();
    int c0 = n_commit, f0 = n_fault;
    arm();
    do_write(2'b01, 32'h0000_0100);
    settle();
    expect_none("R4 cr3 with paging off", c0, f0);
    arm();
    do_write(2'b10, 32'h0000_0020);
    settle();
    expect_none("R6 cr4 pae with pg clear", c0, f0);
  endtask

  // R5 and R2: turning paging on loads from current CR3
  task automatic t_enable();
    int c0 = n_commit;
    put_tbl(32'h100, 64'h0000_0000_1111_1001, 64'h0000_0000_2222_2003 & ~64'h2,
            64'h0000_0000_3333_3000, 64'h0000_000F_4444_4001);
    arm();
    do_write(2'b00, 32'h8000_0001);
    settle();
    expect_load("R5 pg set", c0, 1'b0);
    set_exp_from(32'h100);
    check_regs("R5 regs");
    check("R2 word count", 64'(acnt), 64'd8);
    for (int k = 0; k < 8; k++) check("R2 read order", {32'd0, alog[k]}, 64'(32'h100 + 4*k));
  endtask

  // R2 R3 R4: CR3 low bits ignored, selector picks by bits 31:30
  task automatic t_cr3();
    int c0 = n_commit;
    put_tbl(32'h200, 64'h0000_0000_AAAA_A001, 64'h0000_0000_BBBB_B001,
            64'h0000_0000_CCCC_C001, 64'h0000_0000_DDDD_D001);
    arm();
    do_write(2'b01, 32'h0000_021F);
    settle();
    expect_load("R4 cr3 write", c0, 1'b0);
    check("R2 base low bits ignored", {32'd0, alog[0]}, 64'h200);
    set_exp_from(32'h200);
    check_regs("R3 select");
  endtask

  // R8 R9: reserved bit with present -> fault, regs kept
  task automatic t_fault();
    int c0 = n_commit, f0 = n_fault;
    put_tbl(32'h300, 64'h0000_0000_5555_5001, 64'h0000_0000_6666_6001,
            64'h0000_0000_7777_7041, 64'h0000_0000_8888_8001);
    check("R8 bench rule", 64'(bench_bad(64'h41)), 64'd1);
    arm();
    do_write(2'b01, 32'h0000_0300);
    settle();
    check("R9 fault pulse", 64'(n_fault - f0), 64'd1);
    check("R9 no commit", 64'(n_commit - c0), 64'd0);
    check("R9 errcode zero", 64'(n_badcode), 64'd0);
    check_regs("R9 regs kept");
  endtask

  // R8: non-present entries skip the check
  task automatic t_not_present();
    int c0 = n_commit;
    put_tbl(32'h300, 64'h8000_0000_0000_01E6, 64'h0000_0000_6666_6001,
            64'h0000_0000_7777_7001, 64'h0000_0000_8888_8001);
    arm();
    do_write(2'b01, 32'h0000_0300);
    settle();
    expect_load("R8 not present unchecked", c0, 1'b0);
    set_exp_from(32'h300);
    check_regs("R8 regs");
  endtask

  // R8: upper boundary at PA_W
  task automatic t_high_bits();
    int c0 = n_commit, f0 = n_fault;
    put_tbl(32'h340, 64'h0000_0000_1000_0001, (64'd1 << PA_W) | 64'd1,
            64'h0000_0000_2000_0001, 64'h0000_0000_3000_0001);
    arm();
    do_write(2'b01, 32'h0000_0340);
    settle();
    check("R8 bit PA_W reserved", 64'(n_fault - f0), 64'd1);
    check_regs("R8 regs kept");
    put_tbl(32'h340, 64'h0000_0000_1000_0001, (64'd1 << (PA_W - 1)) | 64'd1,
            64'h0000_0000_2000_0001, 64'h0000_0000_3000_0001);
    arm();
    do_write(2'b01, 32'h0000_0340);
    settle();
    expect_load("R8 bit PA_W-1 allowed", c0, 1'b0);
    set_exp_from(32'h340);
    check_regs("R8 regs high");
  endtask

  // R5: only watched CR0 bits trigger
  task automatic t_cr0_bits();
    int c0 = n_commit, f0 = n_fault;
    arm();
    do_write(2'b00, cur_cr0 | 32'h2);
    settle();
    expect_none("R5 unwatched bit", c0, f0);
    put_tbl(32'h340, 64'h0000_0000_1100_0001, 64'h0000_0000_1200_0001,
            64'h0000_0000_1300_0001, 64'h0000_0000_1400_0001);
    arm();
    do_write(2'b00, cur_cr0 | 32'h4000_0000);
    settle();
    expect_load("R5 cd toggle", c0, 1'b0);
    set_exp_from(32'h340);
    check_regs("R5 regs cd");
  endtask

  // R6: CR4 triggers
  task automatic t_cr4_bits();
    int c0;
    int f0;
    c0 = n_commit;
    arm();
    do_write(2'b10, cur_cr4 | 32'h80);
    settle();
    expect_load("R6 pge toggle", c0, 1'b0);
    c0 = n_commit; f0 = n_fault;
    arm();
    do_write(2'b10, cur_cr4 & ~32'h20);
    settle();
    expect_none("R6 pae cleared", c0, f0);
    arm();
    do_write(2'b10, cur_cr4 | 32'h20);
    settle();
    expect_load("R6 pae restored", c0, 1'b0);
  endtask

  // R7: task switch
  task automatic t_task();
    int c0 = n_commit, f0 = n_fault;
    arm();
    do_write(2'b11, cur_cr3);
    settle();
    expect_none("R7 same cr3", c0, f0);
    arm();
    do_write(2'b11, 32'h0000_0200);
    settle();
    expect_load("R7 new cr3", c0, 1'b0);
    set_exp_from(32'h200);
    check_regs("R7 regs");
  endtask

  // R11: requests during a load, latest wins
  task automatic t_pending();
    int c0 = n_commit;
    int n = 0;
    arm();
    do_write(2'b01, 32'h0000_0100);
    while (!busy && n < 20) begin
      @(negedge clk);
      n++;
    end
    check("R10 busy during fetch", 64'(busy), 64'd1);
    acnt = 0;
    do_write(2'b01, 32'h0000_0300);
    do_write(2'b01, 32'h0000_0340);
    settle();
    settle();
    check("R11 two loads", 64'(n_commit - c0), 64'd2);
    check("R11 latest base", {32'd0, alog[acnt - 8]}, 64'h340);
    set_exp_from(32'h340);
    check_regs("R11 regs");
  endtask

  initial begin : main
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inactive();
    t_enable();
    t_cr3();
    t_fault();
    t_not_present();
    t_high_bits();
    t_cr0_bits();
    t_cr4_bits();
    t_task();
    t_pending();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule